// File: doc/BRIEF.md
# DDR SDRAM Command Bus Protocol Watcher

This block sits beside the command bus of a four-bank DDR SDRAM and observes it without driving anything. It decodes the command presented in each clock cycle, keeps a model of every bank (idle, or active with an open row) and runs minimum-gap timers, all counted in clock cycles. If a command breaks a bank-state rule or comes too early, it raises a violation flag and a reason code in the same cycle the command is on the bus.

The decoded command code is also given out every cycle, so a trace or scoreboard can use it directly. A command that is flagged is taken to have been rejected: it changes neither the bank model nor any timer. One bad command therefore does not cause false reports on the commands after it. The data path, strobe capture, power-down, self refresh and electrical limits are outside this block.

Top module: `ddr_cmd_watch`

## Requirements
- R1: The command is decoded from the inputs that are present before a rising edge. When chip select is high or clock enable is low, the code is 0 (deselect) and no violation is raised. Otherwise RAS/CAS/WE give the code as follows: LLL=7 mode set, LLH=6 refresh, LHL=5 precharge, LHH=2 activate, HLL=4 write, HLH=3 read, HHL=8 burst stop, HHH=1 no-op.
- R2: The bank index is {BA1,BA0}. An accepted activate opens that bank. An accepted precharge with A10 low closes only the addressed bank. With A10 high it closes every bank, whatever BA is.
- R3: A read or write to an idle bank gives reason 3. An activate to a bank that is already open gives reason 4.
- R4: A mode set or refresh while any bank is open gives reason 2.
- R5: After an accepted mode set, any command other than deselect or no-op within T_MRD-1 cycles gives reason 1.
- R6: A read or write fewer than T_RCD cycles after the activate of its bank gives reason 5.
- R7: A precharge fewer than T_RAS cycles after the activate of an open bank it closes gives reason 7.
- R8: An activate fewer than T_RC cycles after the last accepted activate of the same bank gives reason 8.
- R9: An activate fewer than T_RP cycles after a precharge of that bank gives reason 6.
- R10: An activate fewer than T_RRD cycles after an activate of any bank gives reason 9.
- R11: A read or write with A10 high starts a lock of BURST_LEN/2 cycles, during which any read or write gives reason 10. The addressed bank closes at once and may be activated again BURST_LEN/2+T_RP cycles after the command.
- R12: The violation flag and reason come out in the same cycle as the offending command, with reason 0 when there is none. A flagged command changes no bank state or timer. When several rules are broken, the reason with the highest precedence is reported, in this order: 1, 10, 2, 3, 4, 5, 7, 8, 6, 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; rising edge samples the bus |
| rstN | input | 1 | Active-low reset; all banks idle, timers clear |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low masks the command |
| bankAddr | input | 2 | Bank select {BA1,BA0} |
| addr | input | ADDR_W | Address bus; bit AP_BIT is A10 |
| cmdCode | output | 4 | Decoded command of this cycle |
| violation | output | 1 | High when this cycle's command breaks a rule |
| reason | output | 4 | Reason code of the violation, 0 if none |

## Verification
Each gap rule is tested with a command one or more cycles too early and then with the same command exactly at its limit. This separates an off-by-one in a timer's load value from a timer that is missing altogether. Precharge is tested in its single-bank form and its all-bank form, and a later read shows which banks stayed open. This tells a correct A10 decode apart from one that ignores BA. Some commands break two rules at once, for example an early activate that hits both the same-bank cycle gap and the precharge gap; these check the precedence. After a flagged activate, the retry that follows one cycle later must be accepted, which shows that the rejected command left the timers alone.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  localparam int BA_W = 2;
  localparam int NB   = 1 << BA_W;

  typedef enum logic [3:0] {
    CMD_DESEL   = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACT     = 4'd2,
    CMD_READ    = 4'd3,
    CMD_WRITE   = 4'd4,
    CMD_PRE     = 4'd5,
    CMD_REFRESH = 4'd6,
    CMD_MODE    = 4'd7,
    CMD_STOP    = 4'd8
  } cmd_e;

  typedef enum logic [3:0] {
    WHY_NONE     = 4'd0,
    WHY_MODE_GAP = 4'd1,
    WHY_NOT_IDLE = 4'd2,
    WHY_RW_IDLE  = 4'd3,
    WHY_ACT_OPEN = 4'd4,
    WHY_RCD      = 4'd5,
    WHY_RP       = 4'd6,
    WHY_RAS      = 4'd7,
    WHY_RC       = 4'd8,
    WHY_RRD      = 4'd9,
    WHY_AP_LOCK  = 4'd10
  } why_e;

  // strobes from control to bank tracker; only accepted commands set them
  typedef struct packed {
    logic            act;
    logic            pre;
    logic            preAll;
    logic            rw;
    logic            autoPre;
    logic            mode;
    logic [BA_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/ddrw_gap_timer.sv
module ddrw_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] loadVal,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (start)       cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ddrw_bank_track.sv
module ddrw_bank_track
  import ddrw_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  output logic [NB-1:0] bankOpen,
  output logic [NB-1:0] rcdBusy,
  output logic [NB-1:0] rasBusy,
  output logic [NB-1:0] rcBusy,
  output logic [NB-1:0] rpBusy,
  output logic          rrdBusy,
  output logic          modeBusy,
  output logic          lockBusy
);
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int MAXL = T_RC + T_RAS + T_RCD + T_RP + T_RRD + T_MRD + BURST_CYC;
  localparam int W = $clog2(MAXL + 1);
  localparam logic [W-1:0] RCD_LD  = W'(T_RCD - 1);
  localparam logic [W-1:0] RAS_LD  = W'(T_RAS - 1);
  localparam logic [W-1:0] RC_LD   = W'(T_RC - 1);
  localparam logic [W-1:0] RP_LD   = W'(T_RP - 1);
  localparam logic [W-1:0] APRP_LD = W'(BURST_CYC + T_RP - 1);
  localparam logic [W-1:0] RRD_LD  = W'(T_RRD - 1);
  localparam logic [W-1:0] MRD_LD  = W'(T_MRD - 1);
  localparam logic [W-1:0] LOCK_LD = W'(BURST_CYC - 1);

  logic apStart;
  assign apStart = stb.rw && stb.autoPre;

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    localparam logic [BA_W-1:0] MY = BA_W'(gi);
    logic hit, actHit, closeHit, apHit, rpStart;
    logic [W-1:0] rpLoad;

    assign hit      = (stb.bank == MY);
    assign actHit   = stb.act && hit;
    assign apHit    = apStart && hit;
    assign closeHit = (stb.pre && hit) || stb.preAll;
    assign rpStart  = closeHit || apHit;
    assign rpLoad   = apHit ? APRP_LD : RP_LD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    bankOpen[gi] <= 1'b0;
      else if (actHit)              bankOpen[gi] <= 1'b1;
      else if (closeHit || apHit)   bankOpen[gi] <= 1'b0;
    end

    ddrw_gap_timer #(.W(W)) u_rcd (.clk(clk), .rstN(rstN), .start(actHit),
                                   .loadVal(RCD_LD), .busy(rcdBusy[gi]));
    ddrw_gap_timer #(.W(W)) u_ras (.clk(clk), .rstN(rstN), .start(actHit),
                                   .loadVal(RAS_LD), .busy(rasBusy[gi]));
    ddrw_gap_timer #(.W(W)) u_rc  (.clk(clk), .rstN(rstN), .start(actHit),
                                   .loadVal(RC_LD), .busy(rcBusy[gi]));
    ddrw_gap_timer #(.W(W)) u_rp  (.clk(clk), .rstN(rstN), .start(rpStart),
                                   .loadVal(rpLoad), .busy(rpBusy[gi]));
  end

  ddrw_gap_timer #(.W(W)) u_rrd  (.clk(clk), .rstN(rstN), .start(stb.act),
                                  .loadVal(RRD_LD), .busy(rrdBusy));
  ddrw_gap_timer #(.W(W)) u_mrd  (.clk(clk), .rstN(rstN), .start(stb.mode),
                                  .loadVal(MRD_LD), .busy(modeBusy));
  ddrw_gap_timer #(.W(W)) u_lock (.clk(clk), .rstN(rstN), .start(apStart),
                                  .loadVal(LOCK_LD), .busy(lockBusy));

  // R3: control never opens a bank that the tracker holds open
  p_act_idle_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |-> !bankOpen[stb.bank]);
  // R2: an accepted activate leaves its bank open
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |=> bankOpen[$past(stb.bank)]);
  // R2: all-bank precharge leaves nothing open
  p_preall_closes_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.preAll |=> (bankOpen == '0));
  // R4: mode set and refresh only when all idle
  p_mode_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.mode |-> (bankOpen == '0));
  // R9: no activate while the precharge gap runs
  p_act_rp_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |-> !rpBusy[stb.bank]);
  // R11: no column command inside an auto-precharge lock
  p_rw_lock_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.rw |-> !lockBusy);
endmodule

// File: rtl/ddrw_rule_ctrl.sv
module ddrw_rule_ctrl
  import ddrw_pkg::*;
#(
  parameter int T_MRD = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            cke,
  input  logic [BA_W-1:0] bankAddr,
  input  logic            a10,
  input  logic [NB-1:0]   bankOpen,
  input  logic [NB-1:0]   rcdBusy,
  input  logic [NB-1:0]   rasBusy,
  input  logic [NB-1:0]   rcBusy,
  input  logic [NB-1:0]   rpBusy,
  input  logic            rrdBusy,
  input  logic            modeBusy,
  input  logic            lockBusy,
  output cmd_e            cmd,
  output why_e            why,
  output strobe_t         stb
);
  logic isAct, isRw, isPre, isModeLike, isReal, rasHit, ok;

  always_comb begin
    if (!cke || csN) cmd = CMD_DESEL;
    else begin
      unique case ({rasN, casN, weN})
        3'b000:  cmd = CMD_MODE;
        3'b001:  cmd = CMD_REFRESH;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WRITE;
        3'b101:  cmd = CMD_READ;
        3'b110:  cmd = CMD_STOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign isAct      = (cmd == CMD_ACT);
  assign isRw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign isPre      = (cmd == CMD_PRE);
  assign isModeLike = (cmd == CMD_MODE) || (cmd == CMD_REFRESH);
  assign isReal     = (cmd != CMD_DESEL) && (cmd != CMD_NOP);
  assign rasHit     = a10 ? |(bankOpen & rasBusy)
                          : (bankOpen[bankAddr] && rasBusy[bankAddr]);

  always_comb begin
    why = WHY_NONE;
    if (modeBusy && isReal)                     why = WHY_MODE_GAP;
    else if (isRw && lockBusy)                  why = WHY_AP_LOCK;
    else if (isModeLike && (bankOpen != '0))    why = WHY_NOT_IDLE;
    else if (isRw && !bankOpen[bankAddr])       why = WHY_RW_IDLE;
    else if (isAct && bankOpen[bankAddr])       why = WHY_ACT_OPEN;
    else if (isRw && rcdBusy[bankAddr])         why = WHY_RCD;
    else if (isPre && rasHit)                   why = WHY_RAS;
    else if (isAct && rcBusy[bankAddr])         why = WHY_RC;
    else if (isAct && rpBusy[bankAddr])         why = WHY_RP;
    else if (isAct && rrdBusy)                  why = WHY_RRD;
  end

  assign ok = (why == WHY_NONE);

  always_comb begin
    stb         = '0;
    stb.bank    = bankAddr;
    stb.act     = ok && isAct;
    stb.pre     = ok && isPre && !a10;
    stb.preAll  = ok && isPre && a10;
    stb.rw      = ok && isRw;
    stb.autoPre = ok && isRw && a10;
    stb.mode    = ok && (cmd == CMD_MODE);
  end

  // R12: a rejected command issues no strobe
  p_reject_silent_r12: assert property (@(posedge clk) disable iff (!rstN)
    (why != WHY_NONE) |-> !(stb.act || stb.pre || stb.preAll || stb.rw || stb.mode));
  // R1: masked cycles are never flagged
  p_masked_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !cke) |-> (why == WHY_NONE));

  if (T_MRD > 1) begin : g_mrd_chk
    // R5: the cycle after a mode set carries no accepted command
    p_mode_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.mode |=> !(stb.act || stb.pre || stb.preAll || stb.rw || stb.mode));
  end
endmodule

// File: rtl/ddr_cmd_watch.sv
module ddr_cmd_watch
  import ddrw_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmdCode,
  output logic              violation,
  output logic [3:0]        reason
);
  strobe_t       stb;
  cmd_e          cmd;
  why_e          why;
  logic [NB-1:0] bankOpen, rcdBusy, rasBusy, rcBusy, rpBusy;
  logic          rrdBusy, modeBusy, lockBusy;

  ddrw_rule_ctrl #(.T_MRD(T_MRD)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankAddr(bankAddr), .a10(addr[AP_BIT]),
    .bankOpen(bankOpen), .rcdBusy(rcdBusy), .rasBusy(rasBusy), .rcBusy(rcBusy),
    .rpBusy(rpBusy), .rrdBusy(rrdBusy), .modeBusy(modeBusy), .lockBusy(lockBusy),
    .cmd(cmd), .why(why), .stb(stb));

  ddrw_bank_track #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD),
    .T_MRD(T_MRD), .BURST_LEN(BURST_LEN)
  ) u_track (
    .clk(clk), .rstN(rstN), .stb(stb),
    .bankOpen(bankOpen), .rcdBusy(rcdBusy), .rasBusy(rasBusy), .rcBusy(rcBusy),
    .rpBusy(rpBusy), .rrdBusy(rrdBusy), .modeBusy(modeBusy), .lockBusy(lockBusy));

  assign cmdCode   = cmd;
  assign reason    = why;
  assign violation = (why != WHY_NONE);
endmodule

// File: tb/ddr_cmd_watch_bench.sv
`timescale 1ns/1ps
module ddr_cmd_watch_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0]  bankAddr = 2'd0;
  logic [12:0] addr = '0;
  logic [3:0]  cmdCode, reason;
  logic        violation;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                         P_ACT = 3'b011, P_WR = 3'b100, P_RD = 3'b101,
                         P_BST = 3'b110, P_NOP = 3'b111;

  always #2 clk = ~clk;

  ddr_cmd_watch u_ddr_cmd_watch (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankAddr(bankAddr), .addr(addr),
    .cmdCode(cmdCode), .violation(violation), .reason(reason));

  task automatic check(input string tag, input logic [3:0] expCmd, input logic [3:0] expWhy);
    nChecks++;
    if (cmdCode !== expCmd || violation !== (expWhy != 4'd0) || reason !== expWhy) begin
      nFails++;
      $display("FAIL %s: cmd=%0d viol=%0b why=%0d expected cmd=%0d viol=%0b why=%0d",
               tag, cmdCode, violation, reason, expCmd, expWhy != 4'd0, expWhy);
    end
  endtask

  // one call = one clock cycle; drive after falling edge, check before rising edge
  task automatic issue(input logic [2:0] pat, input logic [1:0] ba, input logic a10,
                       input logic cs, input logic ck, input logic [3:0] expCmd,
                       input logic [3:0] expWhy, input string tag);
    @(negedge clk);
    {rasN, casN, weN} = pat;
    csN = cs; cke = ck; bankAddr = ba;
    addr = '0; addr[10] = a10;
    #1 check(tag, expCmd, expWhy);
  endtask

  task automatic cmd(input logic [2:0] pat, input logic [1:0] ba, input logic a10,
                     input logic [3:0] expCmd, input logic [3:0] expWhy, input string tag);
    issue(pat, ba, a10, 1'b0, 1'b1, expCmd, expWhy, tag);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cmd(P_NOP, 2'd0, 1'b0, 4'd1, 4'd0, "R1 nop");
  endtask

  task automatic t_reset;
    #1 check("R1 in reset deselect", 4'd0, 4'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    cmd(P_NOP, 2'd0, 1'b0, 4'd1, 4'd0, "R1 nop after reset");
    issue(P_ACT, 2'd1, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0, "R1 cs high masks");
    issue(P_ACT, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, "R1 cke low masks");
  endtask

  task automatic t_rcd_open;                                   // c0..c9
    cmd(P_ACT, 2'd0, 1'b0, 4'd2, 4'd0, "R2 act b0");
    cmd(P_RD,  2'd0, 1'b0, 4'd3, 4'd5, "R6 read too early");
    cmd(P_RD,  2'd1, 1'b0, 4'd3, 4'd3, "R3 read idle bank");
    cmd(P_RD,  2'd0, 1'b0, 4'd3, 4'd0, "R6 read at tRCD");
    cmd(P_WR,  2'd0, 1'b0, 4'd4, 4'd0, "R1 write decode");
    cmd(P_ACT, 2'd0, 1'b0, 4'd2, 4'd4, "R3 act open bank");
    cmd(P_PRE, 2'd0, 1'b0, 4'd5, 4'd0, "R7 pre at tRAS");
    cmd(P_ACT, 2'd0, 1'b0, 4'd2, 4'd8, "R12 tRC outranks tRP");
    nops(1);
    cmd(P_ACT, 2'd0, 1'b0, 4'd2, 4'd0, "R8 act at tRC");
  endtask

  task automatic t_rrd_preall;                                 // c10..c22
    cmd(P_ACT, 2'd1, 1'b0, 4'd2, 4'd9, "R10 act other bank early");
    cmd(P_ACT, 2'd1, 1'b0, 4'd2, 4'd0, "R12 rejected act left tRRD alone");
    cmd(P_MRS, 2'd0, 1'b0, 4'd7, 4'd2, "R4 mode set with open bank");
    cmd(P_REF, 2'd0, 1'b0, 4'd6, 4'd2, "R4 refresh with open bank");
    nops(4);
    cmd(P_PRE, 2'd3, 1'b1, 4'd5, 4'd0, "R2 precharge all");
    cmd(P_ACT, 2'd2, 1'b0, 4'd2, 4'd6, "R9 act before tRP");
    nops(1);
    cmd(P_ACT, 2'd2, 1'b0, 4'd2, 4'd0, "R9 act at tRP");
    cmd(P_RD,  2'd0, 1'b0, 4'd3, 4'd3, "R2 precharge all closed b0");
  endtask

  task automatic t_single_pre;                                 // c23..c34
    cmd(P_ACT, 2'd3, 1'b0, 4'd2, 4'd0, "R10 act at tRRD");
    nops(5);
    cmd(P_PRE, 2'd3, 1'b0, 4'd5, 4'd0, "R2 precharge b3 only");
    cmd(P_RD,  2'd2, 1'b0, 4'd3, 4'd0, "R2 b2 still open");
    cmd(P_RD,  2'd3, 1'b0, 4'd3, 4'd3, "R2 b3 closed");
    cmd(P_ACT, 2'd0, 1'b0, 4'd2, 4'd0, "R8 act b0 again");
    nops(1);
    cmd(P_PRE, 2'd0, 1'b0, 4'd5, 4'd7, "R7 precharge too early");
  endtask

  task automatic t_autopre;                                    // c35..c40
    cmd(P_RD,  2'd2, 1'b1, 4'd3, 4'd0, "R11 read with auto precharge");
    cmd(P_WR,  2'd0, 1'b0, 4'd4, 4'd10, "R11 write inside lock");
    cmd(P_WR,  2'd0, 1'b0, 4'd4, 4'd0, "R12 b0 stayed open after rejected pre");
    cmd(P_RD,  2'd2, 1'b0, 4'd3, 4'd3, "R11 auto precharge closed b2");
    cmd(P_ACT, 2'd2, 1'b0, 4'd2, 4'd6, "R11 act before burst plus tRP");
    cmd(P_ACT, 2'd2, 1'b0, 4'd2, 4'd0, "R11 act at burst plus tRP");
  endtask

  task automatic t_mode_gap;                                   // c41..c54
    nops(5);
    cmd(P_PRE, 2'd0, 1'b1, 4'd5, 4'd0, "R2 precharge all again");
    cmd(P_MRS, 2'd0, 1'b0, 4'd7, 4'd0, "R4 mode set all idle");
    cmd(P_REF, 2'd0, 1'b0, 4'd6, 4'd1, "R5 refresh inside mode gap");
    cmd(P_REF, 2'd0, 1'b0, 4'd6, 4'd0, "R5 refresh after mode gap");
    nops(1);
    cmd(P_BST, 2'd0, 1'b0, 4'd8, 4'd0, "R1 burst stop decode");
    cmd(P_MRS, 2'd0, 1'b0, 4'd7, 4'd0, "R4 second mode set");
    issue(P_ACT, 2'd0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0, "R5 deselect in mode gap");
    cmd(P_NOP, 2'd0, 1'b0, 4'd1, 4'd0, "R5 nop after mode gap");
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_rcd_open;
        t_rrd_preall;
        t_single_pre;
        t_autopre;
        t_mode_gap;
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog: run hung, expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule